// File: doc/BRIEF.md
# E1 Timeslot Code Inserter

This block sits in the serial transmit path of an E1 line. It overwrites chosen 8-bit timeslots of each 256-bit frame with byte patterns that the host programs, and passes every other bit through unchanged. It runs on the line bit clock and takes a frame-sync pulse and one serial data bit per clock. It returns one serial data bit per clock, one clock later.

The host reaches all configuration through a write-only byte port.

- **Per-timeslot codes.** Each timeslot has its own code byte.
- **Timeslot enables.** Four enable bytes say which timeslots carry their own code.
- **Idle code.** A single idle byte, together with four idle-select bytes, fills any timeslot that is idle-selected but not enabled.

An internal position counter follows the frame. It restarts on frame sync and wraps by itself when no sync arrives. A timeslot's content is fixed when that timeslot begins. A write that lands in the middle of a timeslot therefore never splits a byte.

Top module: `e1_slot_inserter`

## Requirements
- R1: Timeslot n (0..31) has its own code byte, written at host address 0x60+n. Different timeslots can carry different codes in the same frame.
- R2: In an enabled timeslot, the output carries the code byte in place of the input. Bit 7 of the code goes out in the first bit period of the timeslot and bit 0 in the last.
- R3: The enable bit of timeslot n is bit (n mod 8) of the enable byte at address 0xA0 + n/8. So timeslot 0 is bit 0 of 0xA0, timeslot 8 is bit 0 of 0xA1, and timeslot 31 is bit 7 of 0xA3. A 1 selects insertion.
- R4: A timeslot that is neither enabled nor idle-selected passes the input bits to the output unchanged.
- R5: The idle code byte is written at address 0x2A. The idle-select bit of timeslot n is bit (n mod 8) of the byte at 0xA4 + n/8. A timeslot that is idle-selected but not enabled carries the idle code, most significant bit first.
- R6: When a timeslot is both enabled and idle-selected, it carries its own code byte and not the idle code.
- R7: Host writes to any address other than 0x2A, 0x60..0x7F and 0xA0..0xA7 change nothing at the output.
- R8: A frame-sync pulse marks the first bit period of timeslot 0, including a pulse that arrives in the middle of a frame. Without a pulse, the position advances one bit per clock and wraps to timeslot 0 after 256 bits.
- R9: A timeslot's source and pattern are taken at its first bit period. A register write during a timeslot first affects the next occurrence of the timeslot it targets.
- R10: The output is registered, so the bit that enters in one clock appears after that clock's edge. Reset clears the output and every register to 0, so after reset every timeslot passes through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | High in the first bit period of timeslot 0 |
| din | input | 1 | Serial transmit data in |
| host_wr | input | 1 | Host write strobe, one clock per write |
| host_addr | input | 8 | Host register address |
| host_wdata | input | 8 | Host write data |
| dout | output | 1 | Serial transmit data out |

## Verification
A wrong position count moves inserted bytes across timeslot boundaries. This shows on the very next byte that is compared, and the bench compares whole bytes per timeslot against patterns that differ from slot to slot. A wrong latch, or a latch taken at the wrong moment, gives a byte with mixed old and new bits in the frame where the write lands. An enable or idle-select bit decoded to the wrong place puts a code into a timeslot that should pass through, or the reverse, and this is visible within one frame of the write.

// File: rtl/e1ins_pkg.sv
package e1ins_pkg;

    localparam int DEF_SLOTS  = 32;
    localparam int DEF_SLOT_W = 8;
    localparam int DEF_ADDR_W = 8;

    typedef enum logic [1:0] {
        SRC_LINE = 2'd0,
        SRC_CODE = 2'd1,
        SRC_IDLE = 2'd2
    } src_e;

endpackage

// File: rtl/e1ins_position.sv
module e1ins_position #(
    parameter int N_SLOTS = e1ins_pkg::DEF_SLOTS,
    parameter int SLOT_W  = e1ins_pkg::DEF_SLOT_W,
    localparam int SW = $clog2(N_SLOTS),
    localparam int BW = $clog2(SLOT_W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fsync,
    output logic [SW-1:0] slot_idx,
    output logic [BW-1:0] bit_idx
);

    typedef struct packed {
        logic [SW-1:0] slot;
        logic [BW-1:0] bitn;
    } pos_t;

    localparam logic [SW-1:0] LAST_SLOT = SW'(N_SLOTS - 1);
    localparam logic [BW-1:0] LAST_BIT  = BW'(SLOT_W - 1);

    pos_t pos_q, pos_d, cur;

    always_comb begin
        cur = fsync ? '0 : pos_q;
        pos_d = cur;
        if (cur.bitn == LAST_BIT) begin
            pos_d.bitn = '0;
            pos_d.slot = (cur.slot == LAST_SLOT) ? '0 : cur.slot + 1'b1;
        end else begin
            pos_d.bitn = cur.bitn + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    assign slot_idx = cur.slot;
    assign bit_idx  = cur.bitn;

    AST_SYNC_START: assert property (@(posedge clk) disable iff (!rst_n)
        fsync |=> (fsync || (slot_idx == '0 && bit_idx == BW'(1)))); // R8
    AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!fsync && slot_idx == LAST_SLOT && bit_idx == LAST_BIT)
        |=> (slot_idx == '0 && bit_idx == '0)); // R8

endmodule

// File: rtl/e1ins_regs.sv
module e1ins_regs #(
    parameter int N_SLOTS   = e1ins_pkg::DEF_SLOTS,
    parameter int SLOT_W    = e1ins_pkg::DEF_SLOT_W,
    parameter int AW        = e1ins_pkg::DEF_ADDR_W,
    parameter int CODE_BASE = 'h60,
    parameter int EN_BASE   = 'hA0,
    parameter int ISEL_BASE = 'hA4,
    parameter int IDLE_ADDR = 'h2A,
    localparam int SW    = $clog2(N_SLOTS),
    localparam int N_GRP = N_SLOTS / SLOT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [AW-1:0]     addr,
    input  logic [SLOT_W-1:0] wdata,
    input  logic [SW-1:0]     rd_slot,
    output logic [SLOT_W-1:0] code_o,
    output logic              en_o,
    output logic              isel_o,
    output logic [SLOT_W-1:0] idle_o
);

    typedef struct packed {
        logic [N_SLOTS-1:0][SLOT_W-1:0] codes;
        logic [N_SLOTS-1:0]             en;
        logic [N_SLOTS-1:0]             isel;
        logic [SLOT_W-1:0]              idle;
    } regs_t;

    regs_t rf_q, rf_d;

    always_comb begin
        rf_d = rf_q;
        if (wr) begin
            if (addr == AW'(IDLE_ADDR)) rf_d.idle = wdata;
            for (int i = 0; i < N_SLOTS; i++) begin
                if (addr == AW'(CODE_BASE + i)) rf_d.codes[i] = wdata;
            end
            for (int g = 0; g < N_GRP; g++) begin
                if (addr == AW'(EN_BASE + g))   rf_d.en[g*SLOT_W +: SLOT_W]   = wdata;
                if (addr == AW'(ISEL_BASE + g)) rf_d.isel[g*SLOT_W +: SLOT_W] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rf_q <= '0;
        else        rf_q <= rf_d;
    end

    assign code_o = rf_q.codes[rd_slot];
    assign en_o   = rf_q.en[rd_slot];
    assign isel_o = rf_q.isel[rd_slot];
    assign idle_o = rf_q.idle;

    AST_IDLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == AW'(IDLE_ADDR)) |=> (idle_o == $past(wdata))); // R5

endmodule

// File: rtl/e1ins_slot_engine.sv
module e1ins_slot_engine #(
    parameter int SLOT_W = e1ins_pkg::DEF_SLOT_W,
    localparam int BW = $clog2(SLOT_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              din,
    input  logic [BW-1:0]     bit_idx,
    input  logic [SLOT_W-1:0] ch_code,
    input  logic              ch_en,
    input  logic              ch_idle,
    input  logic [SLOT_W-1:0] idle_code,
    output logic              dout
);
    import e1ins_pkg::*;

    typedef struct packed {
        src_e              src;
        logic [SLOT_W-1:0] pat;
        logic              dout;
    } eng_t;

    localparam logic [BW-1:0] MSB_IDX = BW'(SLOT_W - 1);

    eng_t st_q, st_d;
    src_e src_now;
    logic [SLOT_W-1:0] pat_now;

    always_comb begin
        st_d = st_q;
        if (bit_idx == '0) begin
            if (ch_en) begin
                src_now = SRC_CODE;
                pat_now = ch_code;
            end else if (ch_idle) begin
                src_now = SRC_IDLE;
                pat_now = idle_code;
            end else begin
                src_now = SRC_LINE;
                pat_now = '0;
            end
            st_d.src = src_now;
            st_d.pat = pat_now;
        end else begin
            src_now = st_q.src;
            pat_now = st_q.pat;
        end
        st_d.dout = (src_now == SRC_LINE) ? din : pat_now[MSB_IDX - bit_idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{src: SRC_LINE, pat: '0, dout: 1'b0};
        else        st_q <= st_d;
    end

    assign dout = st_q.dout;

    AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
        (src_now == SRC_LINE) |=> (dout == $past(din))); // R4
    AST_CODE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_idx == '0 && ch_en) |=> (dout == $past(ch_code[SLOT_W-1]))); // R2
    AST_SLOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_idx >= BW'(2)) |-> ($stable(st_q.src) && $stable(st_q.pat))); // R9

endmodule

// File: rtl/e1_slot_inserter.sv
module e1_slot_inserter #(
    parameter int N_SLOTS = e1ins_pkg::DEF_SLOTS,
    parameter int SLOT_W  = e1ins_pkg::DEF_SLOT_W,
    parameter int ADDR_W  = e1ins_pkg::DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fsync,
    input  logic              din,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [SLOT_W-1:0] host_wdata,
    output logic              dout
);
    localparam int SW = $clog2(N_SLOTS);
    localparam int BW = $clog2(SLOT_W);

    logic [SW-1:0]     slot_idx;
    logic [BW-1:0]     bit_idx;
    logic [SLOT_W-1:0] ch_code, idle_code;
    logic              ch_en, ch_idle;

    e1ins_position #(.N_SLOTS(N_SLOTS), .SLOT_W(SLOT_W)) u_pos (
        .clk      (clk),
        .rst_n    (rst_n),
        .fsync    (fsync),
        .slot_idx (slot_idx),
        .bit_idx  (bit_idx)
    );

    e1ins_regs #(.N_SLOTS(N_SLOTS), .SLOT_W(SLOT_W), .AW(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (host_wr),
        .addr    (host_addr),
        .wdata   (host_wdata),
        .rd_slot (slot_idx),
        .code_o  (ch_code),
        .en_o    (ch_en),
        .isel_o  (ch_idle),
        .idle_o  (idle_code)
    );

    e1ins_slot_engine #(.SLOT_W(SLOT_W)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .din       (din),
        .bit_idx   (bit_idx),
        .ch_code   (ch_code),
        .ch_en     (ch_en),
        .ch_idle   (ch_idle),
        .idle_code (idle_code),
        .dout      (dout)
    );

endmodule

// File: tb/e1_slot_inserter_test.sv
module e1_slot_inserter_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fsync = 1'b0;
    logic din = 1'b0;
    logic host_wr = 1'b0;
    logic [7:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic dout;

    int checks = 0;
    int errors = 0;
    logic [7:0] got [32];

    always #10 clk = ~clk;

    e1_slot_inserter uut (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .din(din),
        .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
        .dout(dout)
    );

    // addr[29:22] data[21:14] slot[13:9] pass[8] exp[7:0]
    localparam logic [29:0] VEC [10] = '{
        {8'h60, 8'h81, 5'd0,  1'b1, 8'h00},  // R4 code written, not enabled
        {8'hA0, 8'h01, 5'd0,  1'b0, 8'h81},  // R2 R3 slot 0 enabled
        {8'h7F, 8'h3C, 5'd31, 1'b1, 8'h00},  // R4
        {8'hA3, 8'h80, 5'd31, 1'b0, 8'h3C},  // R3 slot 31 bit 7 of 0xA3
        {8'h2A, 8'hF0, 5'd5,  1'b1, 8'h00},  // R5 idle code, no select
        {8'hA4, 8'h20, 5'd5,  1'b0, 8'hF0},  // R5 slot 5 idle-selected
        {8'hA4, 8'h21, 5'd0,  1'b0, 8'h81},  // R6 code beats idle
        {8'hA1, 8'h01, 5'd8,  1'b0, 8'h00},  // R3 slot 8 bit 0 of 0xA1
        {8'h30, 8'hFF, 5'd3,  1'b1, 8'h00},  // R7 unmapped write
        {8'h68, 8'hA5, 5'd8,  1'b0, 8'hA5}   // R1 own code per slot
    };

    function automatic logic [7:0] pbyte(input int s);
        return {3'b101, 5'(s)};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input logic fs, input logic d, input logic w,
                        input logic [7:0] a, input logic [7:0] wd, output logic o);
        @(negedge clk);
        fsync = fs; din = d; host_wr = w; host_addr = a; host_wdata = wd;
        @(posedge clk);
        #1 o = dout;
    endtask

    task automatic run_frame(input logic sync, input int wpos,
                             input logic [7:0] wa, input logic [7:0] wd);
        logic o;
        for (int p = 0; p < 256; p++) begin
            logic [7:0] b;
            b = pbyte(p / 8);
            tick(sync && p == 0, b[7 - (p % 8)], p == wpos, wa, wd, o);
            got[p / 8][7 - (p % 8)] = o;
        end
    endtask

    task automatic hwrite(input logic [7:0] a, input logic [7:0] wd);
        logic o;
        tick(1'b0, 1'b0, 1'b1, a, wd, o);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; fsync = 1'b0; din = 1'b0; host_wr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic o;
        do_reset();
        check("R10 reset output", {7'd0, dout}, 8'h00);

        for (int i = 0; i < 10; i++) begin
            logic [29:0] v;
            v = VEC[i];
            hwrite(v[29:22], v[21:14]);
            run_frame(1'b1, -1, 8'h00, 8'h00);
            run_frame(1'b1, -1, 8'h00, 8'h00);
            if (v[8]) check("R4/R7 pass slot", got[v[13:9]], pbyte(int'(v[13:9])));
            else      check("R1/R2/R3/R5/R6 slot", got[v[13:9]], v[7:0]);
            check("R4 untouched slot 2", got[2], pbyte(2));
        end

        // R9: write mid-slot, old byte this frame, new byte next frame
        hwrite(8'h61, 8'hFF);
        hwrite(8'hA0, 8'h03);
        run_frame(1'b1, -1, 8'h00, 8'h00);
        check("R9 before write", got[1], 8'hFF);
        run_frame(1'b1, 8 + 3, 8'h61, 8'h00);
        check("R9 mid-slot write holds", got[1], 8'hFF);
        run_frame(1'b1, -1, 8'h00, 8'h00);
        check("R9 next occurrence", got[1], 8'h00);

        // R8: free-running wrap without sync
        run_frame(1'b0, -1, 8'h00, 8'h00);
        check("R8 wrap slot 0", got[0], 8'h81);
        check("R8 wrap slot 31", got[31], 8'h3C);

        // R8: sync arriving mid-frame restarts position
        for (int p = 0; p < 100; p++) tick(p == 0, 1'b0, 1'b0, 8'h00, 8'h00, o);
        run_frame(1'b1, -1, 8'h00, 8'h00);
        check("R8 resync slot 0", got[0], 8'h81);
        check("R8 resync slot 5", got[5], 8'hF0);

        // R10: one clock latency in a pass slot (slot 2 bits)
        tick(1'b1, 1'b0, 1'b0, 8'h00, 8'h00, o);
        for (int p = 1; p < 16; p++) tick(1'b0, 1'b0, 1'b0, 8'h00, 8'h00, o);
        tick(1'b0, 1'b0, 1'b0, 8'h00, 8'h00, o);
        check("R10 pass bit low", {7'd0, o}, 8'h00);
        @(negedge clk);
        din = 1'b1;
        #2 check("R10 not yet visible", {7'd0, dout}, 8'h00);
        @(posedge clk);
        #1 check("R10 visible after edge", {7'd0, dout}, 8'h01);

        // R10: reset clears every register
        do_reset();
        check("R10 reset output again", {7'd0, dout}, 8'h00);
        run_frame(1'b1, -1, 8'h00, 8'h00);
        check("R10 slot 0 cleared", got[0], pbyte(0));
        check("R10 slot 5 cleared", got[5], pbyte(5));
        check("R10 slot 31 cleared", got[31], pbyte(31));

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule